// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Management Bus

This block is a slave on a two-wire SMBus-style management bus. It holds a small bank of 8-bit configuration registers for a clock generator. These registers cover frequency selection, output enables, output drive strength, divider and spread fields, two fixed identification bytes and a programmable read-length byte. The clock and data lines are brought into a faster system clock domain through two-flop synchronizers. Every bus event (clock edges, START, repeated START, STOP) is detected in that domain.

Every transfer is an indexed block transfer.

- **Write.** The host addresses the device for writing and sends a starting index and a byte count. It then sends that many data bytes, which land in consecutive registers.
- **Read.** The host sends the write address and an index. It then issues a repeated START and the read address. The slave answers with the count held in the read-length register, followed by register data from the index upward, until the host declines a byte.

The rest of the chip reads any register through a combinational index/data port.

Top module: `smbus_cfg_bank`

## Requirements
- R1: Address byte 0xD2 is always acknowledged. Address byte 0xD3 is acknowledged only when an index byte has already been received since the last STOP. Any other address byte is not acknowledged, and the slave then ignores the bus until the next START.
- R2: In a write, the slave acknowledges the index byte, the count byte X and each of the first X data bytes. Data byte k (k from 0) goes to register index+k.
- R3: Data bytes beyond the count X of a write are not acknowledged and change no register. A count of 0 means that no data byte is accepted.
- R4: After 0xD3 is acknowledged, the slave sends the value of register 8 first, most significant bit first. It then sends register index, index+1, and so on, one byte per host acknowledge.
- R5: When the host does not acknowledge a read byte, the slave stops driving SDA and stays off the bus until the next START.
- R6: Register 8 resets to 0x09 and accepts writes on all eight bits. The value written is the count sent in later reads.
- R7: Register 6 reads 0x25 and register 7 reads 0x11 at all times. Writes to them are ignored.
- R8: Writes change only these bits:
  - reg0: mask 0x1F
  - reg1: mask 0xFB
  - reg2 and reg3: mask 0x7F each
  - reg4: mask 0xFF
  - reg5: mask 0xF7
  - reg8: mask 0xFF
  - reg10: mask 0x80
  - reg15, reg16 and reg17: mask 0xFF each
  - reg18: mask 0x7F
  - reg19: mask 0xF0
  - reg20: mask 0xFF

  Registers 9, 11 to 14 and 21 ignore every write.
- R9: Reset values:
  - reg1: 0xFF
  - reg2 and reg3: 0x7F (all output enables on)
  - reg4: 0xFF
  - reg5: 0xF5

  All other registers, apart from registers 6 to 8, reset to 0x00.
- R10: The slave changes its SDA drive only while the synchronized SCL is low.
- R11: Indices 22 and above read as 0x00, and writes to them are dropped. They are still acknowledged while the count allows.
- R12: `cfg_data_o` shows the current value of the register selected by `cfg_idx_i`, in the same cycle.
- R13: A STOP clears the received index. A read address sent after a STOP, without a new index, is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| cfg_idx_i | input | 8 | Register index for the internal read port |
| cfg_data_o | output | 8 | Register value at `cfg_idx_i` |

## Verification
The bench sweeps every index through the internal port after reset, then after block writes of four data patterns. It compares each register with the value computed from the reset values and write masks. This catches a wrong mask or a wrong reset value, for example a writable reserved bit or an identification byte that changes.

The bench also covers these boundaries:
- A count that is exceeded by one byte: a slave that ignored the count would acknowledge the extra byte and corrupt the next register.
- A read address with no index, or sent after a STOP: a slave that kept stale state would answer it.
- A read that runs past the end of the bank must return zeros.
- A host that declines the last byte: a slave that missed this would keep pulling SDA into the STOP.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam logic [7:0] DEV_WR_ADDR = 8'hD2;
  localparam logic [7:0] DEV_RD_ADDR = 8'hD3;
  localparam int COUNT_REG = 8;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_IDX, PH_CNT, PH_WDATA, PH_RCNT, PH_RDATA, PH_SKIP
  } phase_t;

  function automatic logic [7:0] reg_reset(input int i);
    case (i)
      1, 4:    return 8'hFF;
      2, 3:    return 8'h7F;
      5:       return 8'hF5;
      6:       return 8'h25;
      7:       return 8'h11;
      8:       return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int i);
    case (i)
      0:                  return 8'h1F;
      1:                  return 8'hFB;
      2, 3, 18:           return 8'h7F;
      4, 8, 15, 16, 17, 20: return 8'hFF;
      5:                  return 8'hF7;
      10:                 return 8'h80;
      19:                 return 8'hF0;
      default:            return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbcfg_linesync.sv
module smbcfg_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[PW-2:0], scl_i};
      sda_pipe <= {sda_pipe[PW-2:0], sda_i};
    end
  end

  assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_prev  = scl_pipe[SYNC_STAGES];
  assign sda_prev  = sda_pipe[SYNC_STAGES];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/smbcfg_regfile.sv
module smbcfg_regfile
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 22,
  parameter int IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [7:0]       cnt_data,
  input  logic [IDX_W-1:0] ext_idx,
  output logic [7:0]       ext_data
);
  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RMASK = reg_wmask(g);
    localparam logic [7:0] RRST  = reg_reset(g);
    if (RMASK == 8'h00) begin : g_const
      assign regs[g] = RRST;
    end else begin : g_flop
      logic [7:0] q;
      logic       hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= RRST;
        else if (hit) q <= (q & ~RMASK) | (wr_data & RMASK);
      end
      assign regs[g] = q;
    end
  end

  always_comb begin
    rd_data  = 8'h00;
    ext_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i))  rd_data  = regs[i];
      if (ext_idx == IDX_W'(i)) ext_data = regs[i];
    end
  end

  assign cnt_data = regs[COUNT_REG];
endmodule

// File: rtl/smbcfg_proto.sv
module smbcfg_proto
  import smbcfg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       cnt_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] ptr_o,
  output logic [7:0]       wr_data,
  output logic [7:0]       remain_o,
  output phase_t           phase_o,
  output logic             sda_pull
);
  phase_t           phase_q, phase_d;
  logic [3:0]       cnt_q, cnt_d;
  logic             slot_q, slot_d;
  logic [7:0]       sh_q, sh_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [7:0]       rem_q, rem_d;
  logic             idxok_q, idxok_d;
  logic             pull_q, pull_d;
  logic             hnack_q, hnack_d;
  logic             is_tx, active, ack_now;

  assign is_tx  = (phase_q == PH_RCNT) || (phase_q == PH_RDATA);
  assign active = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);

  always_comb begin
    phase_d = phase_q; cnt_d = cnt_q; slot_d = slot_q; sh_d = sh_q;
    ptr_d = ptr_q; rem_d = rem_q; idxok_d = idxok_q; pull_d = pull_q;
    hnack_d = hnack_q; wr_en = 1'b0; ack_now = 1'b0;
    if (bus_stop) begin
      phase_d = PH_IDLE; pull_d = 1'b0; idxok_d = 1'b0;
      cnt_d = 4'd0; slot_d = 1'b0;
    end else if (bus_start) begin
      phase_d = PH_DEV; pull_d = 1'b0; cnt_d = 4'd0; slot_d = 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (!slot_q) begin
          if (!is_tx) sh_d = {sh_q[6:0], sda_lvl};
          cnt_d = cnt_q + 4'd1;
        end else if (is_tx) begin
          hnack_d = sda_lvl;
        end
      end
      if (scl_fall) begin
        if (!slot_q && cnt_q == 4'd8) begin
          slot_d = 1'b1;
          if (is_tx) begin
            pull_d = 1'b0;
          end else begin
            case (phase_q)
              PH_DEV:   ack_now = (sh_q == DEV_WR_ADDR) ||
                                  ((sh_q == DEV_RD_ADDR) && idxok_q);
              PH_WDATA: ack_now = (rem_q != 8'd0);
              default:  ack_now = 1'b1;
            endcase
            if (phase_q == PH_WDATA && ack_now) begin
              wr_en = 1'b1;
              ptr_d = ptr_q + 1'b1;
              rem_d = rem_q - 8'd1;
            end
            pull_d = ack_now;
          end
        end else if (!slot_q) begin
          if (is_tx) begin
            sh_d   = {sh_q[6:0], 1'b0};
            pull_d = ~sh_q[6];
          end
        end else begin
          slot_d = 1'b0;
          cnt_d  = 4'd0;
          if (is_tx) begin
            if (hnack_q) begin
              phase_d = PH_SKIP; pull_d = 1'b0;
            end else begin
              sh_d = rd_data; pull_d = ~rd_data[7];
              ptr_d = ptr_q + 1'b1; phase_d = PH_RDATA;
            end
          end else if (!pull_q) begin
            phase_d = PH_SKIP;
          end else begin
            pull_d = 1'b0;
            case (phase_q)
              PH_DEV: begin
                if (sh_q == DEV_WR_ADDR) phase_d = PH_IDX;
                else begin
                  sh_d = cnt_data; pull_d = ~cnt_data[7]; phase_d = PH_RCNT;
                end
              end
              PH_IDX: begin
                ptr_d = sh_q[IDX_W-1:0]; idxok_d = 1'b1; phase_d = PH_CNT;
              end
              PH_CNT: begin
                rem_d = sh_q; phase_d = PH_WDATA;
              end
              default: phase_d = phase_q;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; cnt_q <= 4'd0; slot_q <= 1'b0; sh_q <= 8'h00;
      ptr_q <= '0; rem_q <= 8'h00; idxok_q <= 1'b0; pull_q <= 1'b0;
      hnack_q <= 1'b0;
    end else begin
      phase_q <= phase_d; cnt_q <= cnt_d; slot_q <= slot_d; sh_q <= sh_d;
      ptr_q <= ptr_d; rem_q <= rem_d; idxok_q <= idxok_d; pull_q <= pull_d;
      hnack_q <= hnack_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign wr_data  = sh_q;
  assign remain_o = rem_q;
  assign phase_o  = phase_q;
  assign sda_pull = pull_q;
endmodule

// File: rtl/smbus_cfg_bank.sv
module smbus_cfg_bank
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS    = 22,
  parameter int IDX_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [IDX_W-1:0] cfg_idx_i,
  output logic [7:0]       cfg_data_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic wr_en;
  logic [IDX_W-1:0] ptr;
  logic [7:0] wr_data, rd_data, cnt_data, remain;
  phase_t phase;

  smbcfg_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  smbcfg_proto #(.IDX_W(IDX_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .rd_data(rd_data), .cnt_data(cnt_data), .wr_en(wr_en), .ptr_o(ptr),
    .wr_data(wr_data), .remain_o(remain), .phase_o(phase),
    .sda_pull(sda_pull_o)
  );

  smbcfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr),
    .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_data),
    .cnt_data(cnt_data), .ext_idx(cfg_idx_i), .ext_data(cfg_data_o)
  );
endmodule

// File: rtl/smbus_cfg_bank_chk.sv
module smbus_cfg_bank_chk
  import smbcfg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_lvl,
  input logic             sda_pull_o,
  input logic             wr_en,
  input logic [IDX_W-1:0] ptr,
  input logic [7:0]       remain,
  input phase_t           phase
);
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_lvl));

  p_off_bus_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_pull_o);

  p_write_in_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (phase == PH_WDATA) && (remain != 8'd0));

  p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> remain == $past(remain) - 8'd1);

  p_ptr_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr == $past(ptr) + 1'b1);
endmodule

bind smbus_cfg_bank smbus_cfg_bank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull_o(sda_pull_o),
  .wr_en(wr_en), .ptr(ptr), .remain(remain), .phase(phase)
);

// File: tb/smbus_cfg_bank_tb_top.sv
module smbus_cfg_bank_tb_top;
  localparam int NREG = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pull_o;
  logic [7:0] cfg_idx = 8'h00;
  logic [7:0] cfg_data;
  wire  sda_line = sda_h & ~sda_pull_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [32];

  always #4 clk = ~clk;

  smbus_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .cfg_idx_i(cfg_idx), .cfg_data_o(cfg_data)
  );

  function automatic logic [7:0] m_rst(input int i);
    case (i)
      1: return 8'hFF; 2: return 8'h7F; 3: return 8'h7F; 4: return 8'hFF;
      5: return 8'hF5; 6: return 8'h25; 7: return 8'h11; 8: return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_mask(input int i);
    case (i)
      0: return 8'h1F; 1: return 8'hFB; 2: return 8'h7F; 3: return 8'h7F;
      4: return 8'hFF; 5: return 8'hF7; 8: return 8'hFF; 10: return 8'h80;
      15: return 8'hFF; 16: return 8'hFF; 17: return 8'hFF; 18: return 8'h7F;
      19: return 8'hF0; 20: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input int i);
    return (i < NREG) ? model[i] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    w(5); sda_h = 1'b1; w(5); scl_h = 1'b1; w(10); sda_h = 1'b0; w(10); scl_h = 1'b0;
  endtask

  task automatic bus_stop();
    w(3); sda_h = 1'b0; w(7); scl_h = 1'b1; w(10); sda_h = 1'b1; w(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      w(3); sda_h = b[k]; w(7); scl_h = 1'b1; w(10); scl_h = 1'b0;
    end
    w(3); sda_h = 1'b1; w(7); scl_h = 1'b1; w(5); ack = ~sda_line; w(5); scl_h = 1'b0;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    sda_h = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      w(10); scl_h = 1'b1; w(5); b[k] = sda_line; w(5); scl_h = 1'b0;
    end
    w(3); sda_h = last; w(7); scl_h = 1'b1; w(10); scl_h = 1'b0;
  endtask

  task automatic cfg_chk(input int i, input string tag);
    cfg_idx = 8'(i); w(1);
    chk(tag, cfg_data, m_read(i));
  endtask

  task automatic blk_write(input int idx, input int cnt, input int nsend);
    logic ack;
    bus_start();
    send_byte(8'hD2, ack); chk("R1 write address ack", {7'd0, ack}, 8'd1);
    send_byte(8'(idx), ack); chk("R2 index ack", {7'd0, ack}, 8'd1);
    send_byte(8'(cnt), ack); chk("R2 count ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < nsend; k++) begin
      send_byte(wbuf[k], ack);
      if (k < cnt) begin
        chk("R2 data ack", {7'd0, ack}, 8'd1);
        if (idx + k < NREG)
          model[idx+k] = (model[idx+k] & ~m_mask(idx+k)) | (wbuf[k] & m_mask(idx+k));
      end else begin
        chk("R3 extra byte nack", {7'd0, ack}, 8'd0);
      end
    end
    bus_stop();
  endtask

  task automatic blk_read(input int idx);
    logic ack;
    logic [7:0] b, n;
    bus_start();
    send_byte(8'hD2, ack); chk("R1 write address ack", {7'd0, ack}, 8'd1);
    send_byte(8'(idx), ack); chk("R4 index ack", {7'd0, ack}, 8'd1);
    bus_start();
    send_byte(8'hD3, ack); chk("R1 read address ack", {7'd0, ack}, 8'd1);
    recv_byte(1'b0, n); chk("R4 R6 count byte", n, model[8]);
    for (int k = 0; k < int'(n); k++) begin
      recv_byte(k == int'(n) - 1, b);
      chk("R4 R11 read data", b, m_read(idx + k));
    end
    w(8);
    chk("R5 released after host nack", {7'd0, sda_pull_o}, 8'd0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] pats [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h00};
    for (int i = 0; i < NREG; i++) model[i] = m_rst(i);
    w(5); rst_n = 1'b1; w(5);
    chk("R10 no drive at reset", {7'd0, sda_pull_o}, 8'd0);
    // R9 R7 R6 R11 R12: reset sweep through internal port
    for (int i = 0; i < 24; i++) cfg_chk(i, "R9 R12 reset value");

    // R8: full-bank writes with several patterns
    foreach (pats[p]) begin
      for (int k = 0; k < NREG; k++) wbuf[k] = pats[p];
      blk_write(0, NREG, NREG);
      for (int i = 0; i < 24; i++) cfg_chk(i, "R8 R7 masked write");
    end

    // R6: program read length, then read back
    wbuf[0] = 8'd4; blk_write(8, 1, 1);
    cfg_chk(8, "R6 count register");
    wbuf[0] = 8'h3C; wbuf[1] = 8'hC3; wbuf[2] = 8'h96; wbuf[3] = 8'h69;
    blk_write(15, 4, 4);
    blk_read(14);
    blk_read(19);   // R11: runs past the end of the bank

    // R3: one byte more than the count
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    blk_write(2, 2, 3);
    cfg_chk(2, "R2 first data"); cfg_chk(3, "R2 second data");
    cfg_chk(4, "R3 register after count untouched");
    // R3: zero count
    wbuf[0] = 8'h00; blk_write(0, 0, 1);
    cfg_chk(0, "R3 zero count");

    // R1: foreign address
    bus_start();
    send_byte(8'hA0, ack); chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
    send_byte(8'h00, ack); chk("R1 ignored after nack", {7'd0, ack}, 8'd0);
    bus_stop();
    // R1: read address without index
    bus_start();
    send_byte(8'hD3, ack); chk("R1 read without index nack", {7'd0, ack}, 8'd0);
    bus_stop();
    // R13: index then STOP, then read address
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h06, ack);
    bus_stop();
    bus_start();
    send_byte(8'hD3, ack); chk("R13 stop clears index", {7'd0, ack}, 8'd0);
    bus_stop();

    // R7 R8 R11: read-only, reserved and out-of-range writes
    wbuf[0] = 8'hFF; wbuf[1] = 8'h00;
    blk_write(6, 2, 2);
    cfg_chk(6, "R7 id byte"); cfg_chk(7, "R7 revision byte");
    wbuf[0] = 8'hFF; blk_write(21, 1, 1);
    cfg_chk(21, "R8 reserved register 21");
    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD; blk_write(22, 2, 2);
    cfg_chk(22, "R11 beyond bank"); cfg_chk(23, "R11 beyond bank");
    chk("R10 idle bus undriven", {7'd0, sda_pull_o}, 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule